// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block runs the digital side of a dual-slope analog-to-digital conversion. On a start request it steers the unknown voltage onto an external integrator. It then counts a fixed span of clock cycles on a chain of decimal (BCD) digits. When the chain rolls over from all nines back to zero, the block steers the negative reference onto the integrator instead. It keeps counting from zero until the comparator reports that the integrator output is back at zero.

The count at that moment is frozen and presented as the result. Because the first span is fixed and the second span is measured, the result is proportional to the input voltage. If the comparator never trips before the count reaches all nines, the conversion ends with an over-range indication. The integrator, the analog switch and the comparator sit outside the block. The comparator line is treated as asynchronous and passes through a synchronizer before the sequencer uses it.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset, `inSel` is 00, `done` is 0, `overRange` is 0 and `result` is 0.
- R2: A `startReq` sampled high at a clock edge while `inSel` is 00 sets `inSel` to 01 (unknown input), clears `result`, and clears `done` and `overRange` at that same edge.
- R3: `result` holds `DIGITS` BCD digits, digit 0 in bits [3:0] and digit i in bits [4i+3:4i]. No digit ever exceeds 9, each digit steps from 9 to 0 with a carry into the next digit, and `inSel` never takes the value 11.
- R4: The integrate phase lasts exactly 10^DIGITS cycles with `inSel` at 01. It ends at the edge where the count rolls from all nines to zero, and at that edge `inSel` becomes 10 (negative reference) and `result` reads 0.
- R5: The comparator input passes through two flops. Let the de-integrate phase begin at edge E. If `cmpIn` goes low before edge E+K+1, after being high at every earlier edge of the phase, then the conversion ends at edge E+K+3 with `result` equal to K+2, provided K+2 does not exceed the all-nines value.
- R6: During de-integrate, the count advances by one at each edge where the synchronized comparator is still high (integrator above zero), and it advances at no other edge.
- R7: If the synchronized comparator is still high at an edge where the de-integrate count is all nines, the conversion ends there with `overRange` = 1 and `result` at all nines. A trip seen at that same edge takes priority and gives a normal end.
- R8: At the end of a conversion, `done` rises, `inSel` returns to 00, and `result`, `done` and `overRange` then hold until the next accepted start.
- R9: `startReq` has no effect while `inSel` is not 00: phase lengths and the result are unchanged.
- R10: The comparator is ignored during the integrate phase. A low pulse on it that ends at least two cycles before the phase switch changes neither the phase length nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Conversion start request, sampled while idle |
| cmpIn | input | 1 | Asynchronous comparator: 1 while integrator output is above zero |
| inSel | output | 2 | Integrator input select: 00 none, 01 unknown input, 10 negative reference |
| result | output | 4*DIGITS | BCD count, frozen at end of conversion |
| done | output | 1 | Conversion finished, result valid |
| overRange | output | 1 | Conversion ended without a comparator trip |

## Verification
A wrong phase or select state shows up at `inSel` right away. A switch that comes early or late shows up as a wrong number of cycles with `inSel` at 01, which can be counted on the very first conversion. A counter fault shows up as a non-decimal digit or a wrong carry within ten cycles. A wrong synchronizer depth or a wrong stop priority shifts the frozen result by a count or more, or sets `overRange` at the wrong trip point. Sweeping the trip point over every de-integrate count of a two-digit configuration exposes these faults at the end of each conversion.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam logic [1:0] SEL_IDLE    = 2'b00;
  localparam logic [1:0] SEL_UNKNOWN = 2'b01;
  localparam logic [1:0] SEL_NEGREF  = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_INTEG, ST_DEINT} dssState_t;

  typedef struct packed {
    logic clear;
    logic step;
  } cntStrobe_t;
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= 1'b0;
        else if (s == 0) chain[s] <= asyncIn;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/dss_bcd_count.sv
module dss_bcd_count
  import dss_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntStrobe_t         strobe,
  output logic [4*DIGITS-1:0] count,
  output logic               allNines
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS:0] carry;
  assign carry[0] = 1'b1;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : gDigit
      logic [3:0] digit;
      assign carry[d+1] = carry[d] && (digit == 4'd9);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                         digit <= 4'd0;
        else if (strobe.clear)             digit <= 4'd0;
        else if (strobe.step && carry[d])  digit <= (digit == 4'd9) ? 4'd0 : digit + 4'd1;
      end
      assign count[4*d +: 4] = digit;
    end
  endgenerate

  assign allNines = carry[DIGITS];

  logic unusedW;
  assign unusedW = (W == 0);
endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       cmpSync,
  input  logic       allNines,
  output cntStrobe_t strobe,
  output logic [1:0] inSel,
  output logic       done,
  output logic       overRange
);
  dssState_t state;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE:  strobe.clear = startReq;
      ST_INTEG: strobe.step  = 1'b1;
      ST_DEINT: strobe.step  = cmpSync && !allNines;
      default:  strobe       = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      inSel     <= SEL_IDLE;
      done      <= 1'b0;
      overRange <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (startReq) begin
          state     <= ST_INTEG;
          inSel     <= SEL_UNKNOWN;
          done      <= 1'b0;
          overRange <= 1'b0;
        end
        ST_INTEG: if (allNines) begin
          state <= ST_DEINT;
          inSel <= SEL_NEGREF;
        end
        ST_DEINT: if (!cmpSync) begin
          state <= ST_IDLE;
          inSel <= SEL_IDLE;
          done  <= 1'b1;
        end else if (allNines) begin
          state     <= ST_IDLE;
          inSel     <= SEL_IDLE;
          done      <= 1'b1;
          overRange <= 1'b1;
        end
        default: begin
          state <= ST_IDLE;
          inSel <= SEL_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                cmpIn,
  output logic [1:0]          inSel,
  output logic [4*DIGITS-1:0] result,
  output logic                done,
  output logic                overRange
);
  cntStrobe_t strobe;
  logic       cmpSync;
  logic       allNines;

  dss_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(cmpIn), .syncOut(cmpSync)
  );

  dss_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpSync(cmpSync),
    .allNines(allNines), .strobe(strobe), .inSel(inSel), .done(done),
    .overRange(overRange)
  );

  dss_bcd_count #(.DIGITS(DIGITS)) uCount (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(result), .allNines(allNines)
  );
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                startReq,
  input logic [1:0]          inSel,
  input logic [4*DIGITS-1:0] result,
  input logic                done,
  input logic                overRange
);
  localparam logic [4*DIGITS-1:0] ALL9 = {DIGITS{4'h9}};

  a_r3_sel_legal: assert property (@(posedge clk) disable iff (!rstN)
    inSel != 2'b11);

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : gDig
      a_r3_bcd_digit: assert property (@(posedge clk) disable iff (!rstN)
        result[4*d +: 4] <= 4'd9);
    end
  endgenerate

  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (inSel == 2'b00 && startReq) |=> (inSel == 2'b01 && result == '0 && !done && !overRange));

  a_r4_switch: assert property (@(posedge clk) disable iff (!rstN)
    (inSel == 2'b01 && result == ALL9) |=> (inSel == 2'b10 && result == '0));

  a_r4_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    inSel == 2'b01 |=> inSel != 2'b00);

  a_r7_over_value: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (done && result == ALL9));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startReq) |=> (done && $stable(result) && $stable(overRange)));

  a_r8_idle_sel: assert property (@(posedge clk) disable iff (!rstN)
    done |-> inSel == 2'b00);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    inSel == 2'b10 |=> inSel != 2'b01);
endmodule

bind dual_slope_seq dual_slope_seq_chk #(.DIGITS(DIGITS)) uChk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .inSel(inSel),
  .result(result), .done(done), .overRange(overRange)
);

// File: tb/sim_dual_slope_seq.sv
module sim_dual_slope_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIG = 2;
  localparam int FULL = 100;
  localparam int MAXV = FULL - 1;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic cmpIn = 1'b1;
  logic [1:0] inSel;
  logic [4*DIG-1:0] result;
  logic done, overRange;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_slope_seq #(.DIGITS(DIG), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpIn(cmpIn),
    .inSel(inSel), .result(result), .done(done), .overRange(overRange)
  );

  function automatic logic [4*DIG-1:0] toBcd(int v);
    logic [4*DIG-1:0] r;
    int x = v;
    for (int d = 0; d < DIG; d++) begin
      r[4*d +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic digitsOk();
    bit ok = 1;
    for (int d = 0; d < DIG; d++) if (result[4*d +: 4] > 4'd9) ok = 0;
    if (!ok) check(0, "R3 digit", int'(result), 9);
  endtask

  // One conversion; trip is the K of R5 (large means never trips)
  task automatic convert(int trip, bit glitch, bit lateStart);
    int integCnt = 0;
    int deintCnt = 0;
    int j = 0;
    int expRes, expLen;
    bit expOvr;
    logic [4*DIG-1:0] held;
    @(negedge clk);
    cmpIn = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(inSel == 2'b01 && result == '0 && !done && !overRange, "R2 start",
          int'({inSel, done, overRange}), 4);
    while (inSel == 2'b01 && integCnt < 3 * FULL) begin
      digitsOk();
      if (glitch) cmpIn = !(integCnt >= 10 && integCnt < 20);   // R10
      startReq = lateStart && (integCnt == 50);                  // R9
      integCnt++;
      @(negedge clk);
    end
    startReq = 1'b0;
    check(integCnt == FULL, "R4 integrate length", integCnt, FULL);
    check(inSel == 2'b10 && result == '0, "R4 switch", int'(result), 0);
    while (inSel == 2'b10 && deintCnt < 3 * FULL) begin
      digitsOk();
      if (j == trip) cmpIn = 1'b0;
      startReq = lateStart && (j == 5);                          // R9
      deintCnt++;
      j++;
      @(negedge clk);
    end
    startReq = 1'b0;
    expOvr = (trip + 2 > MAXV);
    expRes = expOvr ? MAXV : trip + 2;
    expLen = expOvr ? FULL : trip + 3;
    check(deintCnt == expLen, "R6 de-integrate length", deintCnt, expLen);
    check(result == toBcd(expRes), expOvr ? "R7 result" : "R5 result",
          int'(result), int'(toBcd(expRes)));
    check(overRange == expOvr, "R7 over-range flag", int'(overRange), int'(expOvr));
    check(done && inSel == 2'b00, "R8 end", int'({done, inSel}), 4);
    held = result;
    cmpIn = 1'b1;
    repeat (4) @(negedge clk);
    check(done && result == held && overRange == expOvr, "R8 hold",
          int'(result), int'(held));
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    check(inSel == 2'b00 && result == '0 && !done && !overRange, "R1 reset",
          int'({inSel, result, done, overRange}), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inSel == 2'b00 && result == '0 && !done && !overRange, "R1 after release",
          int'({inSel, result, done, overRange}), 0);
    for (int k = 0; k < FULL; k++) convert(k, (k % 7) == 0, (k % 5) == 0);
    convert(10000, 1'b0, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule